// File: doc/BRIEF.md
# Parallel-Bus to I2S Stereo Serializer

This block connects a processor's external bus to an audio DAC. It acts as an I2S master. Software writes a 16-bit left sample and a 16-bit right sample into two holding registers through a small write-only address window. It then sets a run bit in a control location. From that point the block divides its master clock by a fixed ratio to form the serial bit clock. It produces the word select and shifts each channel out on the data line, most significant bit first.

At the start of every frame the block copies both holding registers into one 32-bit frame shifter. A write that lands in the middle of a frame therefore changes only the next frame. The same copy raises an interrupt, which asks software for the next pair of samples. The interrupt clears when software writes the right-channel register.

With the default 6.144 MHz master clock and a divide ratio of 4, the bit clock is 1.536 MHz. At 32 bits per frame this gives 48 kHz stereo. The sequencer has four states:
- `ST_IDLE`: all serial outputs are low.
- `ST_PRIME`: one bit-clock period with word select low and data low.
- `ST_LEFT`: left channel bits 0 to 15.
- `ST_RIGHT`: right channel bits 0 to 15.

Its transitions are:
- IDLE to PRIME when the run bit is seen set.
- PRIME to LEFT at the first bit-clock fall, which also loads the frame.
- LEFT to RIGHT after the sixteenth left bit.
- RIGHT to LEFT after the last right bit while the run bit is still set, reloading the frame.
- RIGHT to IDLE after the last right bit once the run bit is clear.

Top module: `i2s_bus_serializer`

## Requirements
- R1: The bit clock is the master clock divided by CLK_DIV (4 by default). It is high for the second half of each period and runs without gaps for as long as the block is running.
- R2: The serial data changes only in a cycle where the bit clock falls. It is stable while the bit clock is high.
- R3: Word select is 0 for left and 1 for right. It takes the new channel's value in the same bit period that carries the last bit of the previous word, one period before the new MSB.
- R4: Each frame carries the left word and then the right word. Each word is 16 bits, MSB first, one bit per bit-clock period.
- R5: A write happens only in a cycle where both the chip select and the write enable are 1. Address 0 writes the left holding register, address 1 the right holding register, and address 2 the control location. Addresses 3 to 7 write nothing.
- R6: Bit 0 of a control write is the run flag, and the other bits are ignored. After the run flag is set from idle, one priming bit period with word select 0 and data 0 comes before the first left MSB.
- R7: Both holding registers are copied into the shifter as the left slot begins. A holding-register write during a frame does not change that frame and appears in the next one.
- R8: The interrupt goes to 1 in the cycle a frame is loaded. It goes to 0 after a write to the right holding register. If both happen in the same cycle, the set wins.
- R9: When the run flag is cleared, the current frame finishes through the right LSB. After that, bit clock, word select and data stay 0 and no further frame starts.
- R10: The active-low reset clears the run flag, both holding registers and the interrupt, and drives all serial outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (6.144 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_addr | input | 3 | Word address within the block |
| bus_wdata | input | 16 | Write data |
| irq | output | 1 | Sample request to the processor, active high |
| i2s_sck | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select (0 left, 1 right) |
| i2s_sd | output | 1 | Serial data |

## Verification
The embedded properties assume the following about the bus:
- Chip select, write enable, address and data are synchronous to the master clock.
- Each write is a single-cycle strobe.
- Reset is released only between clock edges.

The bench respects these assumptions. It changes every bus input on the falling clock edge and holds a strobe for exactly one cycle. Holding-register and control writes are timed well away from frame boundaries, so an ordinary mid-frame write never races the frame load. The one case where the load and a right-register write would share a cycle is left to the embedded property on interrupt rises.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } ser_state_e;

endpackage

// File: rtl/i2s_bus_regs.sv
module i2s_bus_regs #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned ADDR_LEFT  = 0,
    parameter int unsigned ADDR_RIGHT = 1,
    parameter int unsigned ADDR_CTRL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    output logic [DATA_W-1:0] hold_l_o,
    output logic [DATA_W-1:0] hold_r_o,
    output logic              run_flag_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_LEFT  = ADDR_W'(ADDR_LEFT);
    localparam logic [ADDR_W-1:0] A_RIGHT = ADDR_W'(ADDR_RIGHT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);

    logic strobe;
    logic wr_left;
    logic wr_right;
    logic wr_ctrl;

    // A write needs both strobes in the same cycle.
    assign strobe   = cs_i && we_i;
    assign wr_left  = strobe && (addr_i == A_LEFT);
    assign wr_right = strobe && (addr_i == A_RIGHT);
    assign wr_ctrl  = strobe && (addr_i == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l_o <= '0;
            hold_r_o <= '0;
        end else begin
            if (wr_left) begin
                hold_l_o <= wdata_i;
            end
            if (wr_right) begin
                hold_r_o <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_flag_o <= 1'b0;
        end else if (wr_ctrl) begin
            run_flag_o <= wdata_i[0];
        end
    end

    // The frame load sets the request; a right-register write clears it.
    // The set wins when both happen in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (load_i) begin
            irq_o <= 1'b1;
        end else if (wr_right) begin
            irq_o <= 1'b0;
        end
    end

    assert_no_write_without_strobe_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(cs_i && we_i) |=> ($stable(hold_l_o) && $stable(hold_r_o) && $stable(run_flag_o))
    );

    assert_irq_rises_on_load_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(load_i)
    );

    assert_irq_falls_on_right_write_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(cs_i) && $past(we_i) && ($past(addr_i) == A_RIGHT))
    );

endmodule

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic tick_o
);

    localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLK_DIV / 2);

    logic [CNT_W-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run_i || (div_cnt == CNT_LAST)) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CNT_W'(1);
        end
    end

    // Low for the first half of the count, high for the second half.
    // The wrap edge is the falling edge of the bit clock.
    assign sck_o  = (div_cnt >= CNT_HALF);
    assign tick_o = run_i && (div_cnt == CNT_LAST);

    assert_sck_falls_on_wrap_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> $past(tick_o)
    );

    assert_sck_rises_mid_period_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> (run_i && (div_cnt == CNT_HALF))
    );

endmodule

// File: rtl/i2s_tx_fsm.sv
module i2s_tx_fsm
    import i2s_ser_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_flag_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] hold_l_i,
    input  logic [DATA_W-1:0] hold_r_i,
    output logic              running_o,
    output logic              load_o,
    output logic              sd_o,
    output logic              ws_o
);

    localparam int unsigned FRAME_W = 2 * DATA_W;
    localparam int unsigned BIT_W   = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_L = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] LAST_F = BIT_W'(FRAME_W - 1);

    ser_state_e         state_q;
    ser_state_e         state_d;
    logic [BIT_W-1:0]   bit_cnt;
    logic [BIT_W-1:0]   nxt_cnt;
    logic [FRAME_W-1:0] frame_sr;
    logic               ws_q;
    logic               frame_end;
    logic               go_idle;

    assign frame_end = tick_i && (state_q == ST_RIGHT) && (bit_cnt == LAST_F);
    assign go_idle   = frame_end && !run_flag_i;
    assign nxt_cnt   = bit_cnt + BIT_W'(1);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_flag_i) begin
                    state_d = ST_PRIME;
                end
            end
            ST_PRIME: begin
                if (tick_i) begin
                    state_d = ST_LEFT;
                    load_o  = 1'b1;
                end
            end
            ST_LEFT: begin
                if (tick_i && (bit_cnt == LAST_L)) begin
                    state_d = ST_RIGHT;
                end
            end
            ST_RIGHT: begin
                if (frame_end) begin
                    if (run_flag_i) begin
                        state_d = ST_LEFT;
                        load_o  = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shifter, bit counter and word select. All of them change only on a wrap tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_sr <= '0;
            bit_cnt  <= '0;
            ws_q     <= 1'b0;
        end else if (load_o) begin
            frame_sr <= {hold_l_i, hold_r_i};
            bit_cnt  <= '0;
            ws_q     <= 1'b0;
        end else if (go_idle) begin
            frame_sr <= '0;
            bit_cnt  <= '0;
            ws_q     <= 1'b0;
        end else if (tick_i && ((state_q == ST_LEFT) || (state_q == ST_RIGHT))) begin
            frame_sr <= {frame_sr[FRAME_W-2:0], 1'b0};
            bit_cnt  <= nxt_cnt;
            // Word select leads the word by one bit: it is high from the left LSB
            // up to, but not including, the right LSB.
            ws_q     <= (nxt_cnt >= LAST_L) && (nxt_cnt != LAST_F);
        end
    end

    assign running_o = (state_q != ST_IDLE);
    assign sd_o      = ((state_q == ST_LEFT) || (state_q == ST_RIGHT)) && frame_sr[FRAME_W-1];
    assign ws_o      = ws_q;

    assert_idle_lines_low_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sd_o && !ws_o)
    );

    assert_load_starts_left_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        load_o |=> ((state_q == ST_LEFT) && !ws_o)
    );

    assert_left_count_range_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEFT) |-> (bit_cnt <= LAST_L)
    );

    assert_prime_data_low_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> (!sd_o && !ws_o)
    );

endmodule

// File: rtl/i2s_bus_serializer.sv
module i2s_bus_serializer #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned CLK_DIV    = 4,
    parameter int unsigned ADDR_LEFT  = 0,
    parameter int unsigned ADDR_RIGHT = 1,
    parameter int unsigned ADDR_CTRL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              irq,
    output logic              i2s_sck,
    output logic              i2s_ws,
    output logic              i2s_sd
);

    logic [DATA_W-1:0] hold_l;
    logic [DATA_W-1:0] hold_r;
    logic              run_flag;
    logic              running;
    logic              load;
    logic              tick;

    i2s_bus_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .ADDR_LEFT  (ADDR_LEFT),
        .ADDR_RIGHT (ADDR_RIGHT),
        .ADDR_CTRL  (ADDR_CTRL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_i       (bus_cs),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .load_i     (load),
        .hold_l_o   (hold_l),
        .hold_r_o   (hold_r),
        .run_flag_o (run_flag),
        .irq_o      (irq)
    );

    i2s_sck_gen #(
        .CLK_DIV (CLK_DIV)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .sck_o  (i2s_sck),
        .tick_o (tick)
    );

    i2s_tx_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_flag_i (run_flag),
        .tick_i     (tick),
        .hold_l_i   (hold_l),
        .hold_r_i   (hold_r),
        .running_o  (running),
        .load_o     (load),
        .sd_o       (i2s_sd),
        .ws_o       (i2s_ws)
    );

    assert_sd_moves_on_fall_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(i2s_sd) |-> $fell(i2s_sck)
    );

    assert_ws_moves_on_fall_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(i2s_ws) |-> $fell(i2s_sck)
    );

endmodule

// File: tb/i2s_bus_serializer_tb.sv
module i2s_bus_serializer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic        irq;
    logic        sck;
    logic        ws;
    logic        sd;

    always #4 clk = ~clk;

    i2s_bus_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (cs),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .irq       (irq),
        .i2s_sck   (sck),
        .i2s_ws    (ws),
        .i2s_sd    (sd)
    );

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;
    int frame0 = 0;

    always @(posedge clk) cyc++;

    // Serial monitor: captures ws and sd on every rise of the bit clock.
    bit cap_sd [0:4095];
    bit cap_ws [0:4095];
    int n_cap = 0;
    int last_rise = -1000;
    int per_bad = 0;
    int hold_bad = 0;
    bit sck_prev = 1'b0;
    bit rise_sd = 1'b0;
    bit rise_ws = 1'b0;

    always @(negedge clk) begin
        if (sck && !sck_prev) begin
            if (n_cap < 4096) begin
                cap_sd[n_cap] = sd;
                cap_ws[n_cap] = ws;
                n_cap++;
            end
            if ((cyc - last_rise) <= 8 && (cyc - last_rise) != 4) per_bad++;
            last_rise = cyc;
            rise_sd = sd;
            rise_ws = ws;
        end else if (sck && sck_prev) begin
            if (sd !== rise_sd || ws !== rise_ws) hold_bad++;
        end
        sck_prev = sck;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_cycle(input bit c, input bit w, input logic [2:0] a,
                             input logic [15:0] d);
        @(negedge clk);
        cs = c; we = w; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_cycle(1'b1, 1'b1, a, d);
    endtask

    task automatic wait_cap(input int n);
        while (n_cap < n) @(negedge clk);
    endtask

    function automatic logic [15:0] word_at(input int idx);
        logic [15:0] w = '0;
        for (int i = 0; i < 16; i++) w = {w[14:0], cap_sd[idx + i]};
        return w;
    endfunction

    function automatic bit ws_frame_ok(input int f);
        bit ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (cap_ws[f + i] != ((i >= 15) && (i != 31))) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic int next_frame();
        return frame0 + 32 * ((n_cap - frame0) / 32 + 1);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(sck == 0 && ws == 0 && sd == 0, "R10", "serial lines in reset",
              {sck, ws, sd}, 0);
        check(irq == 0, "R10", "irq in reset", irq, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_idle_no_run();
        wr(3'd0, 16'hA5F0);
        wr(3'd1, 16'h1234);
        wr(3'd2, 16'hFFFE);   // R6: bit 0 clear, other bits ignored
        repeat (64) @(negedge clk);
        check(n_cap == 0, "R6", "no bit clock with run bit clear", n_cap, 0);
        check(irq == 0, "R8", "no request before any frame", irq, 0);
    endtask

    task automatic t_frames();
        int base;
        base = n_cap;
        wr(3'd2, 16'h0001);
        frame0 = base + 1;
        wait_cap(frame0 + 96);
        check(cap_sd[base] == 0 && cap_ws[base] == 0, "R6", "priming bit",
              {cap_ws[base], cap_sd[base]}, 0);
        for (int f = 0; f < 3; f++) begin
            check(word_at(frame0 + 32 * f) == 16'hA5F0, "R4", "left word",
                  word_at(frame0 + 32 * f), 16'hA5F0);
            check(word_at(frame0 + 32 * f + 16) == 16'h1234, "R4", "right word",
                  word_at(frame0 + 32 * f + 16), 16'h1234);
            check(ws_frame_ok(frame0 + 32 * f), "R3", "word select pattern",
                  0, 1);
        end
        check(per_bad == 0, "R1", "bit clock period of 4", per_bad, 0);
        check(hold_bad == 0, "R2", "data stable while clock high", hold_bad, 0);
    endtask

    task automatic t_irq();
        int nf;
        wait_cap(next_frame() + 8);
        check(irq == 1, "R8", "request after frame load", irq, 1);
        wr(3'd1, 16'h1234);
        check(irq == 0, "R8", "request cleared by right write", irq, 0);
        nf = next_frame();
        wait_cap(nf + 1);
        check(irq == 1, "R8", "request set at next load", irq, 1);
    endtask

    task automatic t_midframe();
        int k;
        k = next_frame();
        wait_cap(k + 5);
        wr(3'd0, 16'h0FF0);
        wait_cap(k + 64);
        check(word_at(k) == 16'hA5F0, "R7", "current frame keeps old left",
              word_at(k), 16'hA5F0);
        check(word_at(k + 32) == 16'h0FF0, "R7", "next frame takes new left",
              word_at(k + 32), 16'h0FF0);
        check(word_at(k + 48) == 16'h1234, "R7", "right word unchanged",
              word_at(k + 48), 16'h1234);
    endtask

    task automatic t_stop();
        int k;
        k = next_frame();
        wait_cap(k + 10);
        wr(3'd2, 16'h0000);
        repeat (300) @(negedge clk);
        check(n_cap == k + 32, "R9", "frame completes then stops", n_cap, k + 32);
        check(sck == 0 && ws == 0 && sd == 0, "R9", "lines low when stopped",
              {sck, ws, sd}, 0);
    endtask

    task automatic t_decode();
        int base;
        wr(3'd0, 16'h1111);
        wr(3'd1, 16'h2222);
        bus_cycle(1'b1, 1'b0, 3'd0, 16'hDEAD);
        bus_cycle(1'b0, 1'b1, 3'd1, 16'hBEEF);
        bus_cycle(1'b0, 1'b1, 3'd2, 16'h0001);
        for (int a = 3; a < 8; a++) wr(3'(a), 16'hFFFF);
        repeat (50) @(negedge clk);
        check(n_cap == base_guard(), "R5", "unused address or single strobe starts nothing",
              n_cap, base_guard());
        base = n_cap;
        wr(3'd2, 16'h0003);
        frame0 = base + 1;
        wait_cap(frame0 + 32);
        check(word_at(frame0) == 16'h1111, "R5", "left register decode",
              word_at(frame0), 16'h1111);
        check(word_at(frame0 + 16) == 16'h2222, "R5", "right register decode",
              word_at(frame0 + 16), 16'h2222);
    endtask

    int stop_count = 0;
    function automatic int base_guard();
        return stop_count;
    endfunction

    task automatic t_reset_mid();
        int n0;
        wait_cap(frame0 + 40);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sck == 0 && ws == 0 && sd == 0 && irq == 0, "R10",
              "outputs cleared by reset", {irq, sck, ws, sd}, 0);
        rst_n = 1'b1;
        n0 = n_cap;
        repeat (100) @(negedge clk);
        check(n_cap == n0, "R10", "run flag cleared by reset", n_cap, n0);
        wr(3'd2, 16'h0001);
        frame0 = n0 + 1;
        wait_cap(frame0 + 32);
        check(word_at(frame0) == 16'h0000 && word_at(frame0 + 16) == 16'h0000,
              "R10", "holding registers cleared", word_at(frame0), 0);
        wr(3'd2, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_idle_no_run();
        t_frames();
        t_irq();
        t_midframe();
        t_stop();
        stop_count = n_cap;
        t_decode();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule